// File: doc/BRIEF.md
# Operand-Two Barrel Shifter

This block conditions the second source operand of an integer datapath before it reaches the ALU. It takes a data word and moves it in one of four ways: a logical left shift, a logical right shift, an arithmetic right shift or a circular right rotate. It also produces a shifter carry-out, which the flag logic uses when an instruction asks for the condition bits to be updated. The block has no clock and no state. Its output settles in the same cycle as its inputs.

The shift distance comes from one of two sources. The first is a small unsigned immediate with enough bits to reach one less than the data width. The second is the low byte of a register, which can ask for distances well past the word width. Only the register source can reach 32 or more, so the handling of large distances is defined for it. A left rotate is expressed by the caller as a right rotate by the width minus the distance, so no left-rotate mode exists. Immediate-constant expansion and the ALU itself sit outside this block.

Top module: `opnd_shifter`

## Requirements
- R1: With shift_kind = 0 (logical left) and a distance n from 1 to 31, shifted equals op_value shifted left by n with zeros filled in at the bottom. carry_out equals op_value bit 32-n.
- R2: With shift_kind = 1 (logical right) and n from 1 to 31, shifted equals op_value shifted right by n with zeros filled in at the top. carry_out equals op_value bit n-1.
- R3: With shift_kind = 2 (arithmetic right) and n from 1 to 31, the vacated top bits take copies of op_value bit 31. carry_out equals op_value bit n-1.
- R4: With shift_kind = 3 (rotate right) and a distance that is not zero, bits leaving at bit 0 re-enter at bit 31. carry_out equals bit 31 of shifted.
- R5: With amt_from_reg = 0 the distance is amt_imm, and amt_reg has no effect. With amt_from_reg = 1 the distance is amt_reg, and amt_imm has no effect.
- R6: A distance of zero, from either source and in any mode, passes op_value through unchanged, and carry_out equals carry_in. When the distance is not zero, carry_in has no effect.
- R7: A register distance of exactly 32 in a logical mode gives zero. carry_out is op_value bit 0 for a left shift and op_value bit 31 for a right shift.
- R8: A register distance above 32 in a logical mode gives zero, with carry_out 0.
- R9: An arithmetic right shift by a register distance of 32 or more gives 32 copies of op_value bit 31, and carry_out equals that bit.
- R10: A rotate by a register distance uses that distance modulo 32. A rotate by a non-zero multiple of 32 passes op_value through unchanged, with carry_out equal to op_value bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_value | input | 32 | Data word to shift or rotate |
| shift_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_from_reg | input | 1 | 0 selects the immediate distance, 1 the register byte |
| amt_imm | input | 5 | Immediate shift distance |
| amt_reg | input | 8 | Low byte of the register that holds the distance |
| carry_in | input | 1 | Current carry flag |
| shifted | output | 32 | Conditioned operand |
| carry_out | output | 1 | Last bit moved out, or carry_in for a zero distance |

## Verification
The most error-prone overlap is between the range handling and the carry selection. A distance of exactly 32, or a rotate by a multiple of 32, reduces to a zero in the low distance bits. The datapath must then saturate or pass the word through, while the carry path must still report a bit that was shifted out rather than the incoming carry flag. Directed vectors hit the distances 0, 1, 31, 32, 33, 64 and 255 in every mode, with both carry_in values. Random vectors cover the rest of the register-byte range. Each result is compared against a bench model that moves the word one bit at a time and keeps the last bit that fell off as the carry.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;

   typedef enum logic [1:0] {
      FILL_NONE = 2'd0,
      FILL_ZERO = 2'd1,
      FILL_SIGN = 2'd2
   } fill_kind_e;

   typedef struct packed {
      logic is_zero;
      logic is_full;
      logic is_over;
   } amt_class_t;

endpackage

// File: rtl/opsh_amount.sv
module opsh_amount #(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8,
   localparam int IMM_W    = $clog2(DATA_W)
) (
   input  logic                 from_reg,
   input  logic [IMM_W-1:0]     imm_amt,
   input  logic [REG_AMT_W-1:0] reg_amt,
   output logic [IMM_W-1:0]     low_amt,
   output opsh_pkg::amt_class_t amt_cls
);
   localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

   logic [REG_AMT_W-1:0] amt_full;

   always_comb begin
      if (from_reg) amt_full = reg_amt;
      else          amt_full = {{(REG_AMT_W-IMM_W){1'b0}}, imm_amt};
   end

   assign low_amt         = amt_full[IMM_W-1:0];
   assign amt_cls.is_zero = (amt_full == '0);
   assign amt_cls.is_full = (amt_full == FULL_AMT);
   assign amt_cls.is_over = (amt_full > FULL_AMT);

   always_comb begin
      p_amt_class_onehot_r5: assert ($onehot0({amt_cls.is_zero, amt_cls.is_full, amt_cls.is_over}))
         else $error("amount class flags overlap");
      p_imm_in_range_r5: assert (from_reg || !(amt_cls.is_full || amt_cls.is_over))
         else $error("immediate distance reached word width");
   end
endmodule

// File: rtl/opsh_rotator.sv
module opsh_rotator #(
   parameter int DATA_W  = 32,
   parameter bit STAGED  = 1'b1,
   localparam int IMM_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [IMM_W-1:0]  rot_amt,
   output logic [DATA_W-1:0] dout
);
   generate
      if (STAGED) begin : g_staged
         logic [DATA_W-1:0] stage [IMM_W+1];
         assign stage[0] = din;
         for (genvar s = 0; s < IMM_W; s++) begin : g_stage
            localparam int STEP = 1 << s;
            always_comb begin
               if (rot_amt[s])
                  stage[s+1] = {stage[s][STEP-1:0], stage[s][DATA_W-1:STEP]};
               else
                  stage[s+1] = stage[s];
            end
         end
         assign dout = stage[IMM_W];
      end else begin : g_flat
         logic [2*DATA_W-1:0] doubled;
         assign doubled = {din, din} >> rot_amt;
         assign dout    = doubled[DATA_W-1:0];
      end
   endgenerate

   always_comb begin
      p_rot_keeps_ones_r4: assert ($countones(dout) == $countones(din))
         else $error("rotator lost or gained bits");
   end
endmodule

// File: rtl/opsh_fill.sv
module opsh_fill #(
   parameter int DATA_W = 32,
   localparam int IMM_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]  rot_in,
   input  logic [IMM_W-1:0]   low_amt,
   input  opsh_pkg::fill_kind_e fill_kind,
   input  logic               sign_bit,
   input  logic               saturate,
   output logic [DATA_W-1:0]  fill_out
);
   import opsh_pkg::*;

   logic [DATA_W-1:0] keep_mask;
   logic [DATA_W-1:0] fill_bits;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         assign keep_mask[i] = ((i + int'(low_amt)) < DATA_W);
      end
   endgenerate

   always_comb begin
      fill_bits = (fill_kind == FILL_SIGN && sign_bit) ? '1 : '0;
      if (fill_kind == FILL_NONE)
         fill_out = rot_in;
      else if (saturate)
         fill_out = fill_bits;
      else
         fill_out = (rot_in & keep_mask) | (fill_bits & ~keep_mask);
   end

   always_comb begin
      p_zero_fill_top_r2: assert (!(fill_kind == FILL_ZERO && low_amt != '0) || fill_out[DATA_W-1] == 1'b0)
         else $error("zero fill left a one in the top bit");
      p_sat_uniform_r9: assert (!(fill_kind != FILL_NONE && saturate) || fill_out == '0 || fill_out == '1)
         else $error("saturated result not uniform");
   end
endmodule

// File: rtl/opsh_carry.sv
module opsh_carry #(
   parameter int DATA_W = 32,
   localparam int IMM_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]     src,
   input  logic [IMM_W-1:0]      low_amt,
   input  opsh_pkg::amt_class_t  amt_cls,
   input  opsh_pkg::shift_kind_e kind,
   input  logic                  carry_in,
   input  logic                  sign_bit,
   output logic                  carry_out
);
   import opsh_pkg::*;

   logic [IMM_W-1:0] last_idx;
   logic             last_bit;

   assign last_idx = low_amt - 1'b1;

   always_comb begin
      last_bit = (low_amt == '0) ? src[DATA_W-1] : src[last_idx];
      if (amt_cls.is_zero)
         carry_out = carry_in;
      else begin
         unique case (kind)
            SK_ROR:  carry_out = last_bit;
            SK_ASR:  carry_out = (amt_cls.is_full || amt_cls.is_over) ? sign_bit : last_bit;
            default: carry_out = amt_cls.is_over ? 1'b0 : last_bit;
         endcase
      end
   end

   always_comb begin
      p_asr_big_carry_r9: assert (!(kind == SK_ASR && (amt_cls.is_full || amt_cls.is_over)) || carry_out == src[DATA_W-1])
         else $error("arithmetic carry differs from sign");
   end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
   parameter int DATA_W    = 32,
   parameter int REG_AMT_W = 8,
   parameter bit STAGED    = 1'b1,
   localparam int IMM_W    = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]    op_value,
   input  logic [1:0]           shift_kind,
   input  logic                 amt_from_reg,
   input  logic [IMM_W-1:0]     amt_imm,
   input  logic [REG_AMT_W-1:0] amt_reg,
   input  logic                 carry_in,
   output logic [DATA_W-1:0]    shifted,
   output logic                 carry_out
);
   import opsh_pkg::*;

   generate
      if ((DATA_W < 2) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 2");
      end
      if (REG_AMT_W <= IMM_W) begin : g_bad_amt
         $error("REG_AMT_W must exceed the immediate width");
      end
   endgenerate

   shift_kind_e kind;
   logic [IMM_W-1:0]  low_amt;
   amt_class_t        amt_cls;
   logic              is_left;
   logic              sign_bit;
   logic [DATA_W-1:0] rev_in;
   logic [DATA_W-1:0] work;
   logic [DATA_W-1:0] rotated;
   logic [DATA_W-1:0] filled;
   logic [DATA_W-1:0] rev_out;
   fill_kind_e        fill_kind;
   logic              saturate;

   assign kind     = shift_kind_e'(shift_kind);
   assign is_left  = (kind == SK_LSL);
   assign sign_bit = op_value[DATA_W-1];

   opsh_amount #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_amount (
      .from_reg (amt_from_reg),
      .imm_amt  (amt_imm),
      .reg_amt  (amt_reg),
      .low_amt  (low_amt),
      .amt_cls  (amt_cls)
   );

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_rev
         assign rev_in[i]  = op_value[DATA_W-1-i];
         assign rev_out[i] = filled[DATA_W-1-i];
      end
   endgenerate

   assign work = is_left ? rev_in : op_value;

   opsh_rotator #(.DATA_W(DATA_W), .STAGED(STAGED)) u_rotator (
      .din     (work),
      .rot_amt (low_amt),
      .dout    (rotated)
   );

   always_comb begin
      unique case (kind)
         SK_ROR:  fill_kind = FILL_NONE;
         SK_ASR:  fill_kind = FILL_SIGN;
         default: fill_kind = FILL_ZERO;
      endcase
   end

   assign saturate = amt_cls.is_full || amt_cls.is_over;

   opsh_fill #(.DATA_W(DATA_W)) u_fill (
      .rot_in    (rotated),
      .low_amt   (low_amt),
      .fill_kind (fill_kind),
      .sign_bit  (sign_bit),
      .saturate  (saturate),
      .fill_out  (filled)
   );

   assign shifted = is_left ? rev_out : filled;

   opsh_carry #(.DATA_W(DATA_W)) u_carry (
      .src       (work),
      .low_amt   (low_amt),
      .amt_cls   (amt_cls),
      .kind      (kind),
      .carry_in  (carry_in),
      .sign_bit  (sign_bit),
      .carry_out (carry_out)
   );

   always_comb begin
      p_zero_pass_r6: assert (!amt_cls.is_zero || (shifted == op_value && carry_out == carry_in))
         else $error("zero distance altered operand or carry");
      p_lsl_low_bit_r1: assert (!(kind == SK_LSL && !amt_cls.is_zero) || shifted[0] == 1'b0)
         else $error("left shift left a one in bit 0");
      p_asr_keeps_sign_r3: assert (kind != SK_ASR || shifted[DATA_W-1] == op_value[DATA_W-1])
         else $error("arithmetic shift changed the sign");
      p_ror_carry_msb_r4: assert (!(kind == SK_ROR && !amt_cls.is_zero) || carry_out == shifted[DATA_W-1])
         else $error("rotate carry differs from result top bit");
      p_logic_over_zero_r8: assert (!((kind == SK_LSL || kind == SK_LSR) && amt_cls.is_over) || (shifted == '0 && carry_out == 1'b0))
         else $error("over-range logical shift not cleared");
   end
endmodule

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_value = '0;
   logic [1:0]  shift_kind = '0;
   logic        amt_from_reg = 1'b0;
   logic [4:0]  amt_imm = '0;
   logic [7:0]  amt_reg = '0;
   logic        carry_in = 1'b0;
   logic [31:0] shifted;
   logic        carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   opnd_shifter u_opnd_shifter (
      .op_value     (op_value),
      .shift_kind   (shift_kind),
      .amt_from_reg (amt_from_reg),
      .amt_imm      (amt_imm),
      .amt_reg      (amt_reg),
      .carry_in     (carry_in),
      .shifted      (shifted),
      .carry_out    (carry_out)
   );

   function automatic logic [32:0] model(input logic [31:0] v, input logic [1:0] k,
                                         input int n, input logic c);
      logic [31:0] w = v;
      logic        cy = c;
      for (int i = 0; i < n; i++) begin
         case (k)
            2'd0: begin cy = w[31]; w = {w[30:0], 1'b0}; end
            2'd1: begin cy = w[0];  w = {1'b0, w[31:1]}; end
            2'd2: begin cy = w[0];  w = {w[31], w[31:1]}; end
            default: begin cy = w[0]; w = {w[0], w[31:1]}; end
         endcase
      end
      return {cy, w};
   endfunction

   function automatic string tag_of(input logic [1:0] k, input int n);
      if (n == 0) return "R6";
      if (k == 2'd3) return (n > 31) ? "R10" : "R4";
      if (k == 2'd2) return (n > 31) ? "R9" : "R3";
      if (n == 32) return "R7";
      if (n > 32) return "R8";
      return (k == 2'd0) ? "R1" : "R2";
   endfunction

   task automatic apply(input logic [31:0] v, input logic [1:0] k, input logic sel,
                        input logic [4:0] imm, input logic [7:0] rg, input logic c,
                        input string tag);
      logic [32:0] exp;
      int n;
      @(posedge clk);
      op_value = v; shift_kind = k; amt_from_reg = sel;
      amt_imm = imm; amt_reg = rg; carry_in = c;
      n = sel ? int'(rg) : int'(imm);
      exp = model(v, k, n, c);
      @(negedge clk);
      checks++;
      if (shifted !== exp[31:0] || carry_out !== exp[32]) begin
         errors++;
         $display("FAIL %s: kind=%0d n=%0d v=%08h got %08h/%0b expected %08h/%0b",
                  tag, k, n, v, shifted, carry_out, exp[31:0], exp[32]);
      end
   endtask

   initial begin
      int dir_amts [7] = '{0, 1, 31, 32, 33, 64, 255};
      logic [31:0] pats [3] = '{32'h8000_0001, 32'h6E4C_39A5, 32'hFFFF_FFFE};
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: idle inputs give a zero result and zero carry (R6)
      @(negedge clk);
      checks++;
      if (shifted !== 32'h0 || carry_out !== 1'b0) begin
         errors++;
         $display("FAIL R6 idle: got %08h/%0b expected 00000000/0", shifted, carry_out);
      end
      // directed corner distances, every mode, both carry values
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 7; a++)
            for (int p = 0; p < 3; p++)
               for (int c = 0; c < 2; c++)
                  apply(pats[p], 2'(k), 1'b1, 5'd0, 8'(dir_amts[a]), 1'(c),
                        tag_of(2'(k), dir_amts[a]));
      // immediate source: register byte ignored (R5)
      apply(32'hA5A5_0F0F, 2'd1, 1'b0, 5'd4, 8'd200, 1'b1, "R5");
      apply(32'h1234_5678, 2'd0, 1'b0, 5'd0, 8'd7, 1'b1, "R5");
      apply(32'hC000_0003, 2'd3, 1'b0, 5'd31, 8'd32, 1'b0, "R5");
      // register source: immediate ignored (R5)
      apply(32'hA5A5_0F0F, 2'd1, 1'b1, 5'd17, 8'd4, 1'b0, "R5");
      apply(32'h8765_4321, 2'd2, 1'b1, 5'd3, 8'd0, 1'b1, "R5");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] v = $urandom;
         logic [1:0]  k = 2'($urandom);
         logic        sel = 1'($urandom);
         logic [4:0]  imm = 5'($urandom);
         logic [7:0]  rg = ($urandom % 4 == 0) ? 8'($urandom % 70) : 8'($urandom);
         logic        c = 1'($urandom);
         apply(v, k, sel, imm, rg, c, tag_of(k, sel ? int'(rg) : int'(imm)));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule